// File: doc/BRIEF.md
# Configuration Header Write Filter

This block owns the 256-byte configuration header of one bus function and decides what each incoming configuration write may change. A write arrives as a sequence of single-byte beats, one per clock, each carrying a byte offset and a data byte. The last beat of a transaction is flagged. Each beat is checked against a writability map that the current header type selects. Read-only bytes are dropped. The status byte for built-in self test always stores zero. A write to the low command byte raises a one-cycle strobe that carries the I/O-enable and memory-enable bits.

The six base address registers take raw bytes while a transaction runs. When the last beat is applied, every base address register touched during the transaction is ANDed with its size mask. That last beat can sit anywhere in the header. The block then pulses one update bit per touched register. The expansion-ROM bytes work the same way: a touch anywhere in the transaction gives a single update pulse at its end.

The kind, size, default base and prefetch attribute of each base address register are parameters. The reset image of each register is its default base ANDed with its mask, with the type flag bits ORed in. The whole header can be read one 32-bit word at a time through a combinational read port.

Top module: `cfg_hdr_wfilter`

## Requirements
- R1: After reset, bytes 0-1 hold the vendor code and bytes 2-3 the device code, both little-endian. Each base address register word holds (default base AND mask), ORed with 0x1 for an I/O register, or with 0x8 for a memory register that has the prefetch attribute. Every other byte is zero, and all strobes are low.
- R2: Header type 0x00 and header type 0x80 both accept writes and share one writable set. The writable offsets are 0x04, 0x05, 0x0C, 0x0D, 0x0F, 0x10-0x27, 0x30-0x33 and 0x3C. A beat to any other offset leaves the header unchanged.
- R3: With any other header type value, every beat is dropped and no command strobe or update strobe is raised.
- R4: An accepted beat to offset 0x0F stores 0x00 whatever its data.
- R5: An accepted beat to offset 0x04 raises cmd_stb_o in the following cycle, with cmd_io_en_o equal to data bit 0 and cmd_mem_en_o equal to data bit 1. Beats to other offsets raise no command strobe.
- R6: An accepted beat to offset 0x10-0x27 stores its byte unmasked and marks base address register ((offset - 0x10) >> 2) as touched. Before the transaction's last beat, the raw byte is what the read port returns.
- R7: On the beat with wr_last_i high, the word of every touched base address register is ANDed with its mask. bar_upd_o then pulses for exactly one cycle in the next cycle, bit i for register i. All touch marks are then cleared, and the last beat itself need not address a base address register.
- R8: The I/O mask is ~(ports - 1) | 0x1. The memory mask is ~((pages << 12) - 1) | 0xF. An unused register has mask 0, so it always reads zero after a transaction ends.
- R9: If any beat of a transaction hits offsets 0x30-0x33, rom_upd_o pulses once, in the cycle after the last beat, and not before.
- R10: rd_data_o returns bytes 4*rd_word_i to 4*rd_word_i+3 of the current header, lowest offset in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_type_i | input | 8 | Header type that selects the writability map |
| wr_valid_i | input | 1 | Write beat present |
| wr_addr_i | input | 8 | Byte offset of the beat |
| wr_data_i | input | 8 | Byte value of the beat |
| wr_last_i | input | 1 | Beat is the last of its transaction |
| rd_word_i | input | 6 | Word index for the read port |
| rd_data_o | output | 32 | Header word at rd_word_i |
| bar_upd_o | output | 6 | One-cycle update pulse per touched base address register |
| rom_upd_o | output | 1 | One-cycle expansion-ROM update pulse |
| cmd_stb_o | output | 1 | One-cycle command byte strobe |
| cmd_io_en_o | output | 1 | I/O enable carried with the command strobe |
| cmd_mem_en_o | output | 1 | Memory enable carried with the command strobe |

## Verification
The hardest case to reach is a register that holds raw, unmasked bits while its touch mark survives across beats that go elsewhere. The transaction must then end on an offset outside every base address register. Stimulus gets there with multi-beat transactions that keep wr_last_i low. These beats write bytes that the mask will later clear, and the bench reads the raw word between beats. The transaction then closes on an unrelated offset, or touches two registers far apart, and the bench checks both the masked word and the exact strobe pattern. A ROM touch spread over non-last beats shows that its pulse waits for the end.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;

    localparam int unsigned NUM_BARS  = 6;
    localparam int unsigned CFG_BYTES = 256;
    localparam int unsigned BAR_BYTE0 = 16;

    localparam logic [7:0] HDR_SINGLE = 8'h00;
    localparam logic [7:0] HDR_MULTI  = 8'h80;

    localparam logic [7:0] OFF_CMD    = 8'h04;
    localparam logic [7:0] OFF_CMD_HI = 8'h05;
    localparam logic [7:0] OFF_CLS    = 8'h0C;
    localparam logic [7:0] OFF_LAT    = 8'h0D;
    localparam logic [7:0] OFF_BIST   = 8'h0F;
    localparam logic [7:0] OFF_BAR_LO = 8'h10;
    localparam logic [7:0] OFF_BAR_HI = 8'h27;
    localparam logic [7:0] OFF_ROM_LO = 8'h30;
    localparam logic [7:0] OFF_ROM_HI = 8'h33;
    localparam logic [7:0] OFF_ILINE  = 8'h3C;

    typedef enum logic [1:0] {
        BAR_UNUSED = 2'd0,
        BAR_IO     = 2'd1,
        BAR_MEM32  = 2'd2
    } bar_kind_e;

    typedef struct packed {
        logic [CFG_BYTES-1:0][7:0] cfg;
        logic [NUM_BARS-1:0]       bar_touch;
        logic                      rom_touch;
        logic [NUM_BARS-1:0]       bar_stb;
        logic                      rom_stb;
        logic                      cmd_stb;
        logic                      cmd_io;
        logic                      cmd_mem;
    } cfgw_state_t;

    function automatic logic in_bar_range(input logic [7:0] off);
        return (off >= OFF_BAR_LO) && (off <= OFF_BAR_HI);
    endfunction

    function automatic logic in_rom_range(input logic [7:0] off);
        return (off >= OFF_ROM_LO) && (off <= OFF_ROM_HI);
    endfunction

    function automatic logic is_writable(input logic [7:0] off);
        return (off == OFF_CMD) || (off == OFF_CMD_HI) || (off == OFF_CLS) ||
               (off == OFF_LAT) || (off == OFF_BIST) || (off == OFF_ILINE) ||
               in_bar_range(off) || in_rom_range(off);
    endfunction

endpackage

// File: rtl/cfgw_wmap.sv
module cfgw_wmap
    import cfgw_pkg::*;
(
    input  logic [7:0] hdr_type_i,
    input  logic [7:0] off_i,
    output logic       wr_ok_o
);

    logic hdr_ok;

    always_comb begin
        case (hdr_type_i)
            HDR_SINGLE, HDR_MULTI: hdr_ok = 1'b1;
            default:               hdr_ok = 1'b0;
        endcase
        wr_ok_o = hdr_ok && is_writable(off_i);
    end

endmodule

// File: rtl/cfgw_bar_mask.sv
module cfgw_bar_mask
    import cfgw_pkg::*;
#(
    parameter logic [1:0]  KIND = 2'd0,
    parameter logic [31:0] SIZE = 32'd0,
    parameter logic [31:0] BASE = 32'd0,
    parameter bit          PREF = 1'b0
) (
    output logic [31:0] mask_o,
    output logic [31:0] init_o
);

    localparam logic [31:0] IO_MASK  = ~(SIZE - 32'd1) | 32'h0000_0001;
    localparam logic [31:0] MEM_MASK = ~((SIZE << 12) - 32'd1) | 32'h0000_000F;

    generate
        if (KIND == BAR_IO) begin : g_io
            assign mask_o = IO_MASK;
            assign init_o = (BASE & IO_MASK) | 32'h0000_0001;
        end else if (KIND == BAR_MEM32) begin : g_mem
            assign mask_o = MEM_MASK;
            assign init_o = (BASE & MEM_MASK) | (PREF ? 32'h0000_0008 : 32'h0);
        end else begin : g_none
            assign mask_o = 32'h0;
            assign init_o = 32'h0;
        end
    endgenerate

endmodule

// File: rtl/cfg_hdr_wfilter.sv
module cfg_hdr_wfilter
    import cfgw_pkg::*;
#(
    parameter logic [15:0]            VENDOR_CODE = 16'hABCD,
    parameter logic [15:0]            DEVICE_CODE = 16'h1234,
    parameter logic [NUM_BARS*2-1:0]  BAR_KINDS   = 12'h029,
    parameter logic [NUM_BARS*32-1:0] BAR_SIZES   = {32'd0, 32'd0, 32'd0,
                                                     32'd1, 32'd4, 32'd16},
    parameter logic [NUM_BARS*32-1:0] BAR_BASES   = {32'd0, 32'd0, 32'd0,
                                                     32'hE000_1000, 32'hF000_0000,
                                                     32'h0000_C000},
    parameter logic [NUM_BARS-1:0]    BAR_PREF    = 6'b000010
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [7:0]          hdr_type_i,
    input  logic                wr_valid_i,
    input  logic [7:0]          wr_addr_i,
    input  logic [7:0]          wr_data_i,
    input  logic                wr_last_i,
    input  logic [5:0]          rd_word_i,
    output logic [31:0]         rd_data_o,
    output logic [NUM_BARS-1:0] bar_upd_o,
    output logic                rom_upd_o,
    output logic                cmd_stb_o,
    output logic                cmd_io_en_o,
    output logic                cmd_mem_en_o
);

    logic [NUM_BARS-1:0][31:0] bar_mask;
    logic [NUM_BARS-1:0][31:0] bar_init;
    logic                      wr_ok;
    cfgw_state_t               st_d, st_q, st_rst;

    // Per-register mask and reset image, fixed by parameters
    generate
        for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
            cfgw_bar_mask #(
                .KIND (BAR_KINDS[2*b +: 2]),
                .SIZE (BAR_SIZES[32*b +: 32]),
                .BASE (BAR_BASES[32*b +: 32]),
                .PREF (BAR_PREF[b])
            ) u_mask (
                .mask_o (bar_mask[b]),
                .init_o (bar_init[b])
            );
        end
    endgenerate

    cfgw_wmap u_wmap (
        .hdr_type_i (hdr_type_i),
        .off_i      (wr_addr_i),
        .wr_ok_o    (wr_ok)
    );

    always_comb begin
        st_rst        = '0;
        st_rst.cfg[0] = VENDOR_CODE[7:0];
        st_rst.cfg[1] = VENDOR_CODE[15:8];
        st_rst.cfg[2] = DEVICE_CODE[7:0];
        st_rst.cfg[3] = DEVICE_CODE[15:8];
        for (int b = 0; b < NUM_BARS; b++) begin
            for (int k = 0; k < 4; k++) begin
                st_rst.cfg[BAR_BYTE0 + 4*b + k] = bar_init[b][8*k +: 8];
            end
        end
    end

    always_comb begin
        logic [NUM_BARS-1:0] touch;
        logic                rom;
        logic [2:0]          bar_idx;
        logic [7:0]          wbyte;

        st_d         = st_q;
        st_d.bar_stb = '0;
        st_d.rom_stb = 1'b0;
        st_d.cmd_stb = 1'b0;
        touch        = st_q.bar_touch;
        rom          = st_q.rom_touch;
        bar_idx      = 3'((wr_addr_i - OFF_BAR_LO) >> 2);
        wbyte        = (wr_addr_i == OFF_BIST) ? 8'h00 : wr_data_i;

        if (wr_valid_i) begin
            if (wr_ok) begin
                st_d.cfg[wr_addr_i] = wbyte;
                for (int b = 0; b < NUM_BARS; b++) begin
                    if (in_bar_range(wr_addr_i) && (bar_idx == 3'(b))) begin
                        touch[b] = 1'b1;
                    end
                end
                if (in_rom_range(wr_addr_i)) begin
                    rom = 1'b1;
                end
                if (wr_addr_i == OFF_CMD) begin
                    st_d.cmd_stb = 1'b1;
                    st_d.cmd_io  = wr_data_i[0];
                    st_d.cmd_mem = wr_data_i[1];
                end
            end
            if (wr_last_i) begin
                // End of transaction: trim every touched register to its mask
                for (int b = 0; b < NUM_BARS; b++) begin
                    for (int k = 0; k < 4; k++) begin
                        if (touch[b]) begin
                            st_d.cfg[BAR_BYTE0 + 4*b + k] =
                                st_d.cfg[BAR_BYTE0 + 4*b + k] & bar_mask[b][8*k +: 8];
                        end
                    end
                end
                st_d.bar_stb = touch;
                st_d.rom_stb = rom;
                touch        = '0;
                rom          = 1'b0;
            end
        end

        st_d.bar_touch = touch;
        st_d.rom_touch = rom;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o    = {st_q.cfg[{rd_word_i, 2'd3}], st_q.cfg[{rd_word_i, 2'd2}],
                           st_q.cfg[{rd_word_i, 2'd1}], st_q.cfg[{rd_word_i, 2'd0}]};
    assign bar_upd_o    = st_q.bar_stb;
    assign rom_upd_o    = st_q.rom_stb;
    assign cmd_stb_o    = st_q.cmd_stb;
    assign cmd_io_en_o  = st_q.cmd_io;
    assign cmd_mem_en_o = st_q.cmd_mem;

endmodule

// File: rtl/cfg_hdr_wfilter_chk.sv
module cfg_hdr_wfilter_chk
    import cfgw_pkg::*;
(
    input logic                      clk,
    input logic                      rst_n,
    input logic [7:0]                hdr_type_i,
    input logic                      wr_valid_i,
    input logic [7:0]                wr_addr_i,
    input logic                      wr_last_i,
    input logic [NUM_BARS-1:0]       bar_upd_o,
    input logic                      rom_upd_o,
    input logic                      cmd_stb_o,
    input logic [CFG_BYTES-1:0][7:0] cfg_i
);

    logic hdr_ok;
    assign hdr_ok = (hdr_type_i == HDR_SINGLE) || (hdr_type_i == HDR_MULTI);

    // R7
    bar_upd_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|bar_upd_o) |-> $past(wr_valid_i && wr_last_i));

    // R9
    rom_upd_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_upd_o |-> $past(wr_valid_i && wr_last_i));

    // R5
    cmd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_stb_o |-> $past(wr_valid_i && hdr_ok && (wr_addr_i == OFF_CMD)));

    // R4
    bist_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && hdr_ok && (wr_addr_i == OFF_BIST)) |=> (cfg_i[OFF_BIST] == 8'h00));

    // R3
    bad_type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && !hdr_ok && !wr_last_i) |=> (cfg_i == $past(cfg_i)));

endmodule

bind cfg_hdr_wfilter cfg_hdr_wfilter_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_type_i (hdr_type_i),
    .wr_valid_i (wr_valid_i),
    .wr_addr_i  (wr_addr_i),
    .wr_last_i  (wr_last_i),
    .bar_upd_o  (bar_upd_o),
    .rom_upd_o  (rom_upd_o),
    .cmd_stb_o  (cmd_stb_o),
    .cfg_i      (st_q.cfg)
);

// File: tb/cfg_hdr_wfilter_tb.sv
module cfg_hdr_wfilter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 28;

    typedef struct packed {
        logic [3:0]  req;
        logic [7:0]  addr;
        logic [7:0]  data;
        logic        last;
        logic [5:0]  rdi;
        logic [31:0] exp;
        logic [5:0]  ebar;
        logic        erom;
        logic        ecmd;
        logic [1:0]  ebits;   // {mem, io}
    } vec_t;

    // Walked in order; each row's expected word accounts for the rows before it
    localparam vec_t VECS [NVEC] = '{
        '{4'd2,  8'h00, 8'h55, 1'b1, 6'd0,  32'h1234_ABCD, 6'h00, 1'b0, 1'b0, 2'b00}, // R2 read-only id
        '{4'd5,  8'h04, 8'h03, 1'b1, 6'd1,  32'h0000_0003, 6'h00, 1'b0, 1'b1, 2'b11}, // R5
        '{4'd4,  8'h0F, 8'hA5, 1'b1, 6'd3,  32'h0000_0000, 6'h00, 1'b0, 1'b0, 2'b00}, // R4
        '{4'd10, 8'h0C, 8'h10, 1'b1, 6'd3,  32'h0000_0010, 6'h00, 1'b0, 1'b0, 2'b00}, // R10
        '{4'd6,  8'h10, 8'hFF, 1'b0, 6'd4,  32'h0000_C0FF, 6'h00, 1'b0, 1'b0, 2'b00}, // R6 raw
        '{4'd6,  8'h11, 8'hFF, 1'b0, 6'd4,  32'h0000_FFFF, 6'h00, 1'b0, 1'b0, 2'b00}, // R6
        '{4'd6,  8'h12, 8'hFF, 1'b0, 6'd4,  32'h00FF_FFFF, 6'h00, 1'b0, 1'b0, 2'b00}, // R6
        '{4'd8,  8'h13, 8'hFF, 1'b1, 6'd4,  32'hFFFF_FFF1, 6'h01, 1'b0, 1'b0, 2'b00}, // R8 io mask
        '{4'd6,  8'h14, 8'hFF, 1'b0, 6'd5,  32'hF000_00FF, 6'h00, 1'b0, 1'b0, 2'b00}, // R6
        '{4'd6,  8'h15, 8'hFF, 1'b0, 6'd5,  32'hF000_FFFF, 6'h00, 1'b0, 1'b0, 2'b00}, // R6
        '{4'd6,  8'h16, 8'hFF, 1'b0, 6'd5,  32'hF0FF_FFFF, 6'h00, 1'b0, 1'b0, 2'b00}, // R6
        '{4'd8,  8'h17, 8'hFF, 1'b1, 6'd5,  32'hFFFF_C00F, 6'h02, 1'b0, 1'b0, 2'b00}, // R8 mem mask
        '{4'd8,  8'h1C, 8'h5A, 1'b1, 6'd7,  32'h0000_0000, 6'h08, 1'b0, 1'b0, 2'b00}, // R8 unused
        '{4'd6,  8'h18, 8'hFF, 1'b0, 6'd6,  32'hE000_10FF, 6'h00, 1'b0, 1'b0, 2'b00}, // R6
        '{4'd7,  8'h27, 8'h77, 1'b1, 6'd9,  32'h0000_0000, 6'h24, 1'b0, 1'b0, 2'b00}, // R7 two regs
        '{4'd7,  8'h00, 8'h00, 1'b1, 6'd6,  32'hE000_100F, 6'h00, 1'b0, 1'b0, 2'b00}, // R7 masked
        '{4'd9,  8'h30, 8'h01, 1'b0, 6'd12, 32'h0000_0001, 6'h00, 1'b0, 1'b0, 2'b00}, // R9 no early
        '{4'd9,  8'h33, 8'hFE, 1'b1, 6'd12, 32'hFE00_0001, 6'h00, 1'b1, 1'b0, 2'b00}, // R9
        '{4'd2,  8'h3C, 8'h0B, 1'b1, 6'd15, 32'h0000_000B, 6'h00, 1'b0, 1'b0, 2'b00}, // R2
        '{4'd2,  8'h3D, 8'h44, 1'b1, 6'd15, 32'h0000_000B, 6'h00, 1'b0, 1'b0, 2'b00}, // R2 dropped
        '{4'd5,  8'h05, 8'h01, 1'b1, 6'd1,  32'h0000_0103, 6'h00, 1'b0, 1'b0, 2'b00}, // R5 no strobe
        '{4'd5,  8'h04, 8'h02, 1'b1, 6'd1,  32'h0000_0102, 6'h00, 1'b0, 1'b1, 2'b10}, // R5
        '{4'd2,  8'h08, 8'h99, 1'b1, 6'd2,  32'h0000_0000, 6'h00, 1'b0, 1'b0, 2'b00}, // R2 dropped
        '{4'd6,  8'h15, 8'h3F, 1'b0, 6'd5,  32'hFFFF_3F0F, 6'h00, 1'b0, 1'b0, 2'b00}, // R6 raw
        '{4'd7,  8'h3C, 8'h01, 1'b1, 6'd5,  32'hFFFF_000F, 6'h02, 1'b0, 1'b0, 2'b00}, // R7 late end
        '{4'd9,  8'h31, 8'hAA, 1'b0, 6'd12, 32'hFE00_AA01, 6'h00, 1'b0, 1'b0, 2'b00}, // R9
        '{4'd9,  8'h32, 8'hBB, 1'b0, 6'd12, 32'hFEBB_AA01, 6'h00, 1'b0, 1'b0, 2'b00}, // R9
        '{4'd9,  8'h0C, 8'h20, 1'b1, 6'd3,  32'h0000_0020, 6'h00, 1'b1, 1'b0, 2'b00}  // R9 once
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  hdr_type = 8'h00;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [7:0]  wr_data = 8'h00;
    logic        wr_last = 1'b0;
    logic [5:0]  rd_word = 6'd0;
    logic [31:0] rd_data;
    logic [5:0]  bar_upd;
    logic        rom_upd;
    logic        cmd_stb;
    logic        cmd_io;
    logic        cmd_mem;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_hdr_wfilter dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .hdr_type_i   (hdr_type),
        .wr_valid_i   (wr_valid),
        .wr_addr_i    (wr_addr),
        .wr_data_i    (wr_data),
        .wr_last_i    (wr_last),
        .rd_word_i    (rd_word),
        .rd_data_o    (rd_data),
        .bar_upd_o    (bar_upd),
        .rom_upd_o    (rom_upd),
        .cmd_stb_o    (cmd_stb),
        .cmd_io_en_o  (cmd_io),
        .cmd_mem_en_o (cmd_mem)
    );

    task automatic chk(input int req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // One beat; returns at the falling edge after the capturing rising edge
    task automatic beat(input logic [7:0] a, input logic [7:0] d, input logic l);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        wr_last  = l;
        @(negedge clk);
        wr_valid = 1'b0;
        wr_last  = 1'b0;
    endtask

    task automatic read_word(input logic [5:0] i, output logic [31:0] v);
        rd_word = i;
        #1;
        v = rd_data;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual running expected finished");
            finish_run();
        end
    end

    task automatic check_reset_image();
        logic [31:0] v;
        chk(1, "bar strobe", 32'(bar_upd), 32'h0);
        chk(1, "rom strobe", 32'(rom_upd), 32'h0);
        chk(1, "cmd strobe", 32'(cmd_stb), 32'h0);
        read_word(6'd0, v); chk(1, "id word", v, 32'h1234_ABCD);
        read_word(6'd1, v); chk(1, "cmd word", v, 32'h0);
        read_word(6'd4, v); chk(1, "io bar init", v, 32'h0000_C001);
        read_word(6'd5, v); chk(1, "mem bar prefetch init", v, 32'hF000_0008);
        read_word(6'd6, v); chk(1, "mem bar init", v, 32'hE000_1000);
        read_word(6'd7, v); chk(1, "unused bar init", v, 32'h0);
        read_word(6'd15, v); chk(1, "irq word", v, 32'h0);
    endtask

    initial begin
        logic [31:0] v;
        logic [5:0]  s_bar;
        logic        s_rom;
        logic        s_cmd;
        logic [1:0]  s_bits;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_image();   // R1

        for (int n = 0; n < NVEC; n++) begin
            beat(VECS[n].addr, VECS[n].data, VECS[n].last);
            s_bar  = bar_upd;
            s_rom  = rom_upd;
            s_cmd  = cmd_stb;
            s_bits = {cmd_mem, cmd_io};
            read_word(VECS[n].rdi, v);
            chk(int'(VECS[n].req), $sformatf("vec %0d word", n), v, VECS[n].exp);
            chk(7, $sformatf("vec %0d bar strobe", n), 32'(s_bar), 32'(VECS[n].ebar));
            chk(9, $sformatf("vec %0d rom strobe", n), 32'(s_rom), 32'(VECS[n].erom));
            chk(5, $sformatf("vec %0d cmd strobe", n), 32'(s_cmd), 32'(VECS[n].ecmd));
            if (VECS[n].ecmd) begin
                chk(5, $sformatf("vec %0d cmd bits", n), 32'(s_bits), 32'(VECS[n].ebits));
            end
        end

        // R3: unknown header type drops beats and strobes
        hdr_type = 8'h01;
        beat(8'h04, 8'h00, 1'b1);
        chk(3, "cmd strobe bad type", 32'(cmd_stb), 32'h0);
        read_word(6'd1, v); chk(3, "cmd word bad type", v, 32'h0000_0102);
        beat(8'h10, 8'h00, 1'b1);
        chk(3, "bar strobe bad type", 32'(bar_upd), 32'h0);
        read_word(6'd4, v); chk(3, "bar word bad type", v, 32'hFFFF_FFF1);

        // R2: multifunction header type uses the same map
        hdr_type = 8'h80;
        beat(8'h3C, 8'h22, 1'b1);
        read_word(6'd15, v); chk(2, "irq line multi", v, 32'h0000_0022);
        beat(8'h08, 8'h11, 1'b1);
        read_word(6'd2, v); chk(2, "read-only multi", v, 32'h0);

        // R8: mask only clears, flag bit 0 is not forced back on
        hdr_type = 8'h00;
        beat(8'h10, 8'h00, 1'b1);
        chk(8, "bar strobe zero write", 32'(bar_upd), 32'h01);
        read_word(6'd4, v); chk(8, "io bar zero low byte", v, 32'hFFFF_FF00);

        // R1: reset mid-run restores the defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_reset_image();

        done = 1'b1;
        finish_run();
    end

endmodule